// File: doc/BRIEF.md
# SPI Word Control Port

This block is the slave side of a serial control channel. An external host uses it to exchange 32-bit control words with logic inside the chip. The host lowers chip select and first sends an address byte of the kind used on two-wire buses. Its low bit selects the direction of the transaction.

In a write transaction, the data bytes that follow are packed into 32-bit words. Each finished word is handed inward as a one-cycle strobe. In a read transaction, words taken from an internal outbound queue are shifted back to the host. An active-low interrupt tells the host that outbound words are waiting.

The serial pins are oversampled in the system clock domain. The block therefore has a single clock. The serial clock must stay well below the system clock rate.

Top module: `spi_word_port`

## Requirements
- R1: After reset, `spi_irq_n` is high while the queue is empty, and `spi_miso_oe`, `wr_valid` and `rd_pop` are low.
- R2: The first byte after chip select falls is an address byte, received most significant bit first on rising SCK edges. The value 0x80 selects a write transaction.
- R3: In a write transaction, every four bytes form one word, with the first byte in bits 31:24. After the rising edge of the word's 32nd bit, `wr_valid` pulses for exactly one system clock with the word on `wr_word`. Several words may follow one address byte.
- R4: The address value 0x81 selects a read transaction. `spi_miso_oe` rises once the address byte is complete. Each queued word is sent most significant bit first: MISO changes after falling SCK edges and is sampled on rising edges. Taking each word from the queue pulses `rd_pop` once.
- R5: If a word boundary in a read transaction finds the queue empty, MISO sends zeros for that word and `rd_pop` stays low.
- R6: `spi_irq_n` is low while the queue holds words or a word is partly sent. It rises right after the rising SCK edge of the last bit of the last word. It stays low across a word boundary while more words are queued.
- R7: Any address value other than 0x80 or 0x81 makes the rest of the transaction ignored: no `wr_valid`, no `rd_pop`, and `spi_miso_oe` stays low.
- R8: Raising chip select in the middle of a word discards the partial word without a strobe. The next transaction starts again with an address byte.
- R9: `spi_miso_oe` is low during the address byte and while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host, idles low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| spi_irq_n | output | 1 | Active-low outbound-data-pending interrupt |
| wr_word | output | WORD_W | Last word received in a write transaction |
| wr_valid | output | 1 | One-cycle strobe that qualifies `wr_word` |
| rd_word | input | WORD_W | Head entry of the outbound queue |
| rd_avail | input | 1 | Outbound queue is not empty |
| rd_pop | output | 1 | One-cycle request to remove the queue head |

## Verification
A wrong bit count or a misaligned word shows up on the first word of a transaction. Either the strobe value is rotated or byte-swapped, or the strobe fires at the wrong time or not at all, and a value check after chip select rises catches it. A wrong direction decode shows as an enabled MISO driver or a spurious strobe during the address-rejected transactions in the table.

On the read side, a shifter or interrupt fault shows within one word. The host sees wrong bits, the pop count is off, or `spi_irq_n` is still low a few system clocks after the last rising edge. A stale counter after an aborted word corrupts the very next transaction.

// File: rtl/spi_word_port.sv
module spi_word_port #(
  parameter int          WORD_W  = 32,
  parameter logic [7:0]  WR_ADDR = 8'h80,
  parameter logic [7:0]  RD_ADDR = 8'h81
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic              spi_irq_n,
  output logic [WORD_W-1:0] wr_word,
  output logic              wr_valid,
  input  logic [WORD_W-1:0] rd_word,
  input  logic              rd_avail,
  output logic              rd_pop
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(7);
  localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_W - 1);

  typedef enum logic [1:0] {ST_ADDR, ST_WRITE, ST_READ, ST_IGNORE} st_t;

  logic [2:0]        sck_s;
  logic [1:0]        cs_s;
  logic [1:0]        mosi_s;
  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] rx_sh;
  logic [WORD_W-1:0] tx_sh;
  logic              tx_busy;
  logic              miso_q;

  wire sel      = ~cs_s[1];
  wire mosi_b   = mosi_s[1];
  wire sck_rise = sel & sck_s[1] & ~sck_s[2];
  wire sck_fall = sel & ~sck_s[1] & sck_s[2];
  wire [7:0] addr_b = {rx_sh[6:0], mosi_b};
  wire word_end = (cnt == WORD_LAST);
  wire load_now = sck_rise & (((st == ST_ADDR) & (cnt == ADDR_LAST) & (addr_b == RD_ADDR)) |
                              ((st == ST_READ) & word_end));

  assign spi_miso    = miso_q;
  assign spi_miso_oe = sel & (st == ST_READ);
  assign spi_irq_n   = ~(rd_avail | tx_busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s  <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
    end else begin
      sck_s  <= {sck_s[1:0], spi_sck};
      cs_s   <= {cs_s[0], spi_cs_n};
      mosi_s <= {mosi_s[0], spi_mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_ADDR;
      cnt      <= '0;
      rx_sh    <= '0;
      wr_word  <= '0;
      wr_valid <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      if (!sel) begin
        st  <= ST_ADDR;
        cnt <= '0;
      end else if (sck_rise) begin
        case (st)
          ST_ADDR: begin
            rx_sh <= {rx_sh[WORD_W-2:0], mosi_b};
            if (cnt == ADDR_LAST) begin
              cnt <= '0;
              if (addr_b == WR_ADDR)      st <= ST_WRITE;
              else if (addr_b == RD_ADDR) st <= ST_READ;
              else                        st <= ST_IGNORE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_WRITE: begin
            rx_sh <= {rx_sh[WORD_W-2:0], mosi_b};
            cnt   <= word_end ? '0 : cnt + 1'b1;
            if (word_end) begin
              wr_word  <= {rx_sh[WORD_W-2:0], mosi_b};
              wr_valid <= 1'b1;
            end
          end
          ST_READ:  cnt <= word_end ? '0 : cnt + 1'b1;
          default:  cnt <= '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      tx_busy <= 1'b0;
      miso_q  <= 1'b0;
      rd_pop  <= 1'b0;
    end else begin
      rd_pop <= 1'b0;
      if (!sel) begin
        tx_sh   <= '0;
        tx_busy <= 1'b0;
        miso_q  <= 1'b0;
      end else if (load_now) begin
        tx_sh   <= rd_avail ? rd_word : '0;
        tx_busy <= rd_avail;
        rd_pop  <= rd_avail;
      end else if (sck_fall && st == ST_READ) begin
        miso_q <= tx_sh[WORD_W-1];
        tx_sh  <= {tx_sh[WORD_W-2:0], 1'b0};
      end
    end
  end
endmodule

module spi_word_port_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_valid,
  input logic rd_pop,
  input logic rd_avail,
  input logic spi_irq_n,
  input logic spi_miso_oe
);
  a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  a_r4_pop_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop |=> !rd_pop);
  a_r5_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop |-> rd_avail);
  a_r6_irq_release_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_irq_n) |-> !rd_avail);
  a_r7_no_write_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !spi_miso_oe);
endmodule

bind spi_word_port spi_word_port_chk u_spi_word_port_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .rd_pop(rd_pop),
  .rd_avail(rd_avail), .spi_irq_n(spi_irq_n), .spi_miso_oe(spi_miso_oe)
);

// File: tb/test_spi_word_port.sv
module test_spi_word_port;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe, irq_n, wr_valid, rd_pop;
  logic [31:0] wr_word, rd_word;
  logic rd_avail;

  logic [31:0] q [0:7];
  int qh = 0, qt = 0;
  int wr_cnt = 0, pop_cnt = 0;
  logic [31:0] wr_log [0:15];
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  assign rd_avail = (qh != qt);
  assign rd_word  = q[qh % 8];

  spi_word_port i_spi_word_port (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .spi_irq_n(irq_n),
    .wr_word(wr_word), .wr_valid(wr_valid), .rd_word(rd_word),
    .rd_avail(rd_avail), .rd_pop(rd_pop)
  );

  always @(posedge clk) begin
    if (wr_valid) begin
      wr_log[wr_cnt % 16] <= wr_word;
      wr_cnt <= wr_cnt + 1;
    end
    if (rd_pop) begin
      qh <= qh + 1;
      pop_cnt <= pop_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bit_x(input logic b, output logic r);
    @(negedge clk) mosi = b;
    repeat (H) @(negedge clk);
    r = miso;
    sck = 1'b1;
    repeat (H) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic byte_x(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) bit_x(tx[i], rx[i]);
  endtask

  task automatic cs_begin;
    @(negedge clk) cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_end;
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * H) @(negedge clk);
  endtask

  task automatic word_x(input logic [31:0] tx, output logic [31:0] rx);
    for (int k = 3; k >= 0; k--) byte_x(tx[8*k +: 8], rx[8*k +: 8]);
  endtask

  typedef struct packed {
    logic [7:0]  addr;
    logic [31:0] word;
    logic        wr;
  } vec_t;

  localparam vec_t VEC [0:5] = '{
    '{addr: 8'h80, word: 32'hDEADBEEF, wr: 1'b1},
    '{addr: 8'h80, word: 32'h00000001, wr: 1'b1},
    '{addr: 8'h80, word: 32'h80000000, wr: 1'b1},
    '{addr: 8'h00, word: 32'h12345678, wr: 1'b0},
    '{addr: 8'h82, word: 32'hFFFFFFFF, wr: 1'b0},
    '{addr: 8'h01, word: 32'hA5A5A5A5, wr: 1'b0}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic [7:0]  rb;
    logic [31:0] rw;
    logic        r;
    int          w0, p0;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 irq_n", irq_n, 1);
    chk("R1 miso_oe", miso_oe, 0);
    chk("R1 wr_valid", wr_valid, 0);
    chk("R1 rd_pop", rd_pop, 0);

    // R2 R3 R7: table of single-word transactions
    for (int v = 0; v < 6; v++) begin
      w0 = wr_cnt;
      p0 = pop_cnt;
      cs_begin();
      chk("R9 oe before address", miso_oe, 0);
      byte_x(VEC[v].addr, rb);
      repeat (4) @(negedge clk);
      if (!VEC[v].wr) chk("R7 oe after bad address", miso_oe, 0);
      word_x(VEC[v].word, rw);
      cs_end();
      chk(VEC[v].wr ? "R3 strobe count" : "R7 no strobe", wr_cnt - w0, VEC[v].wr ? 1 : 0);
      if (VEC[v].wr) chk("R3 word value", wr_log[(wr_cnt - 1) % 16], VEC[v].word);
      else chk("R7 no pop", pop_cnt - p0, 0);
    end

    // R3: two words after one address byte
    w0 = wr_cnt;
    cs_begin();
    byte_x(8'h80, rb);
    word_x(32'h01234567, rw);
    word_x(32'h89ABCDEF, rw);
    cs_end();
    chk("R3 two strobes", wr_cnt - w0, 2);
    chk("R3 first word", wr_log[w0 % 16], 32'h01234567);
    chk("R3 second word", wr_log[(w0 + 1) % 16], 32'h89ABCDEF);

    // R4 R5 R6: read two queued words, then an empty slot
    @(negedge clk);
    q[qt % 8] = 32'hC0FFEE11; qt++;
    q[qt % 8] = 32'h5A5A0FF0; qt++;
    @(negedge clk);
    chk("R6 irq low with queued data", irq_n, 0);
    p0 = pop_cnt;
    cs_begin();
    byte_x(8'h81, rb);
    repeat (4) @(negedge clk);
    chk("R4 oe after read address", miso_oe, 1);
    word_x(32'h0, rw);
    chk("R4 first read word", rw, 32'hC0FFEE11);
    chk("R6 irq low at word boundary", irq_n, 0);
    for (int k = 3; k >= 1; k--) byte_x(8'h00, rw[8*k +: 8]);
    for (int i = 7; i >= 1; i--) bit_x(1'b0, rw[i]);
    chk("R6 irq low before last bit", irq_n, 0);
    @(negedge clk) mosi = 1'b0;
    repeat (H) @(negedge clk);
    rw[0] = miso;
    sck = 1'b1;
    repeat (5) @(negedge clk);
    chk("R6 irq high after last rising edge", irq_n, 1);
    repeat (H - 5) @(negedge clk);
    sck = 1'b0;
    chk("R4 second read word", rw, 32'h5A5A0FF0);
    chk("R4 pops", pop_cnt - p0, 2);
    word_x(32'h0, rw);
    chk("R5 zeros on empty queue", rw, 32'h0);
    chk("R5 no pop on empty queue", pop_cnt - p0, 2);
    cs_end();
    chk("R9 oe after cs high", miso_oe, 0);

    // R8: aborted partial word, then a clean write
    w0 = wr_cnt;
    cs_begin();
    byte_x(8'h80, rb);
    byte_x(8'h11, rb);
    byte_x(8'h22, rb);
    cs_end();
    chk("R8 partial word dropped", wr_cnt - w0, 0);
    cs_begin();
    byte_x(8'h80, rb);
    word_x(32'hCAFEF00D, rw);
    cs_end();
    chk("R8 next transaction count", wr_cnt - w0, 1);
    chk("R8 next transaction word", wr_log[w0 % 16], 32'hCAFEF00D);

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule